// File: doc/BRIEF.md
# Receive FIFO Controller with Status

This block sits behind a small word-addressed register bus and wraps the receive data FIFO of a 32-bit parallel input link. The link side offers one word per cycle with a valid strobe. Software reads the words out through a data register. It steers the block through a control word and watches a status word. That status word carries the four FIFO level flags as active-high "not" conditions, the sticky overrun and underrun errors and a busy flag.

The almost-empty and almost-full levels are programmable. Four level conditions can latch pending interrupt bits, and each pending bit clears when software writes 1 to it. The interrupt output is a level: it is high while any pending bit is also enabled. A board reset returns every register to its default and then holds the block busy for a settle period. While busy, the FIFO cannot be reached from either side. A typical capture writes receive-FIFO reset, then receive enable, and stops by writing zero to the control word.

Top module: `rxfifo_ctrl`

## Requirements
- R1: After the reset input, the control word (address 0) reads 0, the status word (address 1) reads 0x0000C000, and the threshold register (address 2) reads 0x00200020 (almost-empty level 32 in bits 15:0, almost-full level 32 in bits 23:16).
- R2: While receive enable (control bit 5) is set and the block is not busy, every link word offered when the FIFO is not full is stored. Reads of the data register (address 6) return the stored words in arrival order, one per read, with the value in the read data one cycle after the read strobe.
- R3: With occupancy c, depth D, almost-empty level A and almost-full level F, the status bits are: bit 12 = (c != 0), bit 13 = (c > A), bit 14 = (c + F < D), bit 15 = (c != D).
- R4: A link word offered while the FIFO is full is dropped and sets status bit 23 (overrun). That bit stays set until a status write with bit 23 at 1 or a board reset.
- R5: A data read while the FIFO is empty returns 0 and sets status bit 22 (underrun). That bit stays set until a status write with bit 22 at 1 or a board reset. A status write with 0 in these bits leaves them unchanged.
- R6: With receive enable clear, link words are ignored: nothing is stored and no overrun is raised.
- R7: Writing control bit 2 empties the receive FIFO without changing the error bits. Bit 5 of the same write sets the new receive enable.
- R8: Writing control bit 0 returns all registers and the FIFO to their reset values. It then sets status bit 0 (busy) for SETTLE_CYCLES cycles. While busy, link words are not stored and data reads return 0 without raising underrun. The control, threshold and enable registers stay writable.
- R9: Interrupt pending bits (address 5) 12, 13, 14 and 15 are set when, in turn, the empty (c == 0), almost-empty (c <= A), almost-full (c + F >= D) or full (c == D) condition becomes true, whatever the enables are. Each bit clears when 1 is written to it. The irq output is high exactly while a pending bit has its enable bit set in the enable register (address 4, same bit positions).
- R10: The size register (address 3) reports the FIFO depth D in bits 19:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, valid the cycle after regRd |
| linkValid | input | 1 | Link word valid |
| linkData | input | 32 | Link word |
| irq | output | 1 | Level interrupt request |

## Verification
The bench walks the occupancy through every level from empty to full and back under two threshold settings. It compares all four level flags at each step. An off-by-one comparator, or a swapped almost-empty/almost-full field, would show up at the threshold step. It pushes into a full FIFO and reads from an empty one. A design that stored the extra word, or returned stale data, would break the drained order or the zero result. A design that cleared the errors on a zero write would lose the sticky bits. The board-reset case checks that the busy window really freezes both FIFO sides and that the registers return to their defaults. The interrupt case checks that pending bits latch on condition edges with enables clear, and that the irq output follows only the enabled ones.

// File: rtl/rxfifo_pkg.sv
package rxfifo_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_THR   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_SIZE  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_IEN   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_ISTAT = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_DATA  = 3'd6;

  localparam int BIT_BOARD_RST = 0;
  localparam int BIT_FIFO_RST  = 2;
  localparam int BIT_RX_EN     = 5;
  localparam int BIT_UNDERRUN  = 22;
  localparam int BIT_OVERRUN   = 23;
  localparam int FLAG_LSB      = 12;

  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } fifoCmd_t;
endpackage

// File: rtl/rxfifo_data.sv
module rxfifo_data
  import rxfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoCmd_t         cmd,
  input  logic [WIDTH-1:0] pushData,
  input  logic [15:0]      aeLevel,
  input  logic [7:0]       afLevel,
  output logic [WIDTH-1:0] popData,
  output logic [CNT_W-1:0] count,
  output logic [3:0]       fifoFlags
);
  localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);
  localparam logic [CNT_W+8:0] DEPTH_EXT = (CNT_W + 9)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W+8:0] sumAf;
  logic [16:0]      cntWide;

  always_ff @(posedge clk) begin
    if (cmd.push && !cmd.clear) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (cmd.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (cmd.pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({cmd.push, cmd.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign popData = mem[rdPtr];

  always_comb begin
    sumAf   = (CNT_W + 9)'(count) + (CNT_W + 9)'(afLevel);
    cntWide = 17'(count);
    fifoFlags[0] = (count != '0);
    fifoFlags[1] = (cntWide > 17'(aeLevel));
    fifoFlags[2] = (sumAf < DEPTH_EXT);
    fifoFlags[3] = (count != FULL_CNT);
  end
endmodule

// File: rtl/rxfifo_regs.sv
module rxfifo_regs
  import rxfifo_pkg::*;
#(
  parameter int WIDTH         = 32,
  parameter int DEPTH         = 64,
  parameter int SETTLE_CYCLES = 200,
  parameter int AE_RESET      = 32,
  parameter int AF_RESET      = 32,
  localparam int SET_W = $clog2(SETTLE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              linkValid,
  input  logic [3:0]        fifoFlags,
  input  logic [WIDTH-1:0]  popData,
  output fifoCmd_t          cmd,
  output logic [15:0]       aeLevel,
  output logic [7:0]        afLevel,
  output logic              irq,
  output logic              busy,
  output logic              overrunFlag,
  output logic              underrunFlag,
  output logic [3:0]        irqEnable
);
  localparam logic [SET_W-1:0] SETTLE_INIT = SET_W'(SETTLE_CYCLES);
  localparam logic [15:0]      AE_INIT     = 16'(AE_RESET);
  localparam logic [7:0]       AF_INIT     = 8'(AF_RESET);

  logic             rxEnable;
  logic [SET_W-1:0] settleCnt;
  logic [3:0]       irqPending, condPrev, condNow;
  logic             wrCtrl, wrStat, wrThr, wrIen, wrIstat;
  logic             boardReset, clearReq, dataRead, offerWord;
  logic             overrunEvt, underrunEvt;
  logic [31:0]      statusWord, readMux;
  logic             unusedWrBits;

  assign unusedWrBits = ^{regWrData[31:24], regWrData[11:6], regWrData[4:3], regWrData[1]};

  always_comb begin
    wrCtrl     = regWr && (regAddr == ADDR_CTRL);
    wrStat     = regWr && (regAddr == ADDR_STAT);
    wrThr      = regWr && (regAddr == ADDR_THR);
    wrIen      = regWr && (regAddr == ADDR_IEN);
    wrIstat    = regWr && (regAddr == ADDR_ISTAT);
    boardReset = wrCtrl && regWrData[BIT_BOARD_RST];
    clearReq   = boardReset || (wrCtrl && regWrData[BIT_FIFO_RST]);
    busy       = (settleCnt != '0);
    dataRead   = regRd && (regAddr == ADDR_DATA) && !busy;
    offerWord  = linkValid && rxEnable && !busy;
    cmd.clear  = clearReq;
    cmd.push   = offerWord && fifoFlags[3] && !clearReq;
    cmd.pop    = dataRead && fifoFlags[0] && !clearReq;
    overrunEvt  = offerWord && !fifoFlags[3] && !clearReq;
    underrunEvt = dataRead && !fifoFlags[0];
    condNow    = ~fifoFlags;
  end

  always_comb begin
    statusWord = '0;
    statusWord[0] = busy;
    statusWord[FLAG_LSB +: 4] = fifoFlags;
    statusWord[BIT_UNDERRUN] = underrunFlag;
    statusWord[BIT_OVERRUN]  = overrunFlag;
    readMux = '0;
    case (regAddr)
      ADDR_CTRL:  readMux[BIT_RX_EN] = rxEnable;
      ADDR_STAT:  readMux = statusWord;
      ADDR_THR:   readMux = {8'h00, afLevel, aeLevel};
      ADDR_SIZE:  readMux = {12'h000, 20'(DEPTH)};
      ADDR_IEN:   readMux[FLAG_LSB +: 4] = irqEnable;
      ADDR_ISTAT: readMux[FLAG_LSB +: 4] = irqPending;
      ADDR_DATA:  readMux = cmd.pop ? 32'(popData) : 32'h0;
      default:    readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || boardReset) begin
      rxEnable     <= 1'b0;
      aeLevel      <= AE_INIT;
      afLevel      <= AF_INIT;
      irqEnable    <= '0;
      irqPending   <= '0;
      condPrev     <= 4'b0011;
      overrunFlag  <= 1'b0;
      underrunFlag <= 1'b0;
      regRdData    <= '0;
      settleCnt    <= rstN ? SETTLE_INIT : '0;
    end else begin
      if (busy) settleCnt <= settleCnt - 1'b1;
      if (wrCtrl) rxEnable <= regWrData[BIT_RX_EN];
      if (wrThr) begin
        aeLevel <= regWrData[15:0];
        afLevel <= regWrData[23:16];
      end
      if (wrIen) irqEnable <= regWrData[FLAG_LSB +: 4];
      condPrev   <= condNow;
      irqPending <= (irqPending & ~({4{wrIstat}} & regWrData[FLAG_LSB +: 4]))
                    | (condNow & ~condPrev);
      overrunFlag  <= (overrunFlag & ~(wrStat & regWrData[BIT_OVERRUN])) | overrunEvt;
      underrunFlag <= (underrunFlag & ~(wrStat & regWrData[BIT_UNDERRUN])) | underrunEvt;
      if (regRd) regRdData <= readMux;
    end
  end

  assign irq = |(irqPending & irqEnable);
endmodule

// File: rtl/rxfifo_ctrl.sv
module rxfifo_ctrl
  import rxfifo_pkg::*;
#(
  parameter int DEPTH         = 64,
  parameter int WIDTH         = 32,
  parameter int SETTLE_CYCLES = 200,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              linkValid,
  input  logic [WIDTH-1:0]  linkData,
  output logic              irq
);
  fifoCmd_t         cmd;
  logic [15:0]      aeLevel;
  logic [7:0]       afLevel;
  logic [WIDTH-1:0] popData;
  logic [CNT_W-1:0] count;
  logic [3:0]       fifoFlags, irqEnable;
  logic             busy, overrunFlag, underrunFlag;

  rxfifo_regs #(
    .WIDTH(WIDTH), .DEPTH(DEPTH), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) i_regs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .linkValid(linkValid),
    .fifoFlags(fifoFlags), .popData(popData), .cmd(cmd), .aeLevel(aeLevel),
    .afLevel(afLevel), .irq(irq), .busy(busy), .overrunFlag(overrunFlag),
    .underrunFlag(underrunFlag), .irqEnable(irqEnable)
  );

  rxfifo_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_data (
    .clk(clk), .rstN(rstN), .cmd(cmd), .pushData(linkData),
    .aeLevel(aeLevel), .afLevel(afLevel), .popData(popData),
    .count(count), .fifoFlags(fifoFlags)
  );
endmodule

// File: rtl/rxfifo_ctrl_chk.sv
module rxfifo_ctrl_chk
  import rxfifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic              regRd,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWrData,
  input logic [31:0]       regRdData,
  input logic              irq,
  input fifoCmd_t          cmd,
  input logic [CNT_W-1:0]  count,
  input logic              busy,
  input logic              overrunFlag,
  input logic [3:0]        irqEnable
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic boardRst, ovrClr;
  assign boardRst = regWr && (regAddr == ADDR_CTRL) && regWrData[BIT_BOARD_RST];
  assign ovrClr   = regWr && (regAddr == ADDR_STAT) && regWrData[BIT_OVERRUN];

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT); // R3
  AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rstN)
    (count == FULL_CNT && !cmd.pop && !cmd.clear) |=> (count == FULL_CNT)); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrunFlag && !ovrClr && !boardRst) |=> overrunFlag); // R4
  AST_UDR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && !regWr && regAddr == ADDR_DATA && !busy && count == '0) |=> (regRdData == 32'h0)); // R5
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!cmd.push && !cmd.pop)); // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnable == 4'b0000) |-> !irq); // R9
endmodule

bind rxfifo_ctrl rxfifo_ctrl_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .irq(irq), .cmd(cmd),
  .count(count), .busy(busy), .overrunFlag(overrunFlag), .irqEnable(irqEnable)
);

// File: tb/test_rxfifo_ctrl.sv
`timescale 1ns/1ps
module test_rxfifo_ctrl;
  localparam int D = 64;
  localparam int SETTLE = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0, regRd = 1'b0, linkValid = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0, linkData = '0, regRdData;
  logic irq;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  rxfifo_ctrl #(.DEPTH(D), .WIDTH(32), .SETTLE_CYCLES(SETTLE)) i_rxfifo_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .linkValid(linkValid),
    .linkData(linkData), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    @(negedge clk);
    regRd = 1'b0;
    d = regRdData;
  endtask

  task automatic pushWord(input logic [31:0] d);
    @(negedge clk);
    linkValid = 1'b1; linkData = d;
    @(negedge clk);
    linkValid = 1'b0;
  endtask

  function automatic logic [31:0] flagsOf(input int c, input int a, input int f);
    logic [31:0] v;
    v = '0;
    v[12] = (c != 0);
    v[13] = (c > a);
    v[14] = (c + f < D);
    v[15] = (c != D);
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRead(3'd0, r); check("R1 ctrl", r, 32'h0);
    regRead(3'd1, r); check("R1 status", r, 32'h0000C000);
    regRead(3'd2, r); check("R1 thresholds", r, 32'h00200020);
    check("R1 irq", {31'b0, irq}, 32'h0);
    // R10 size
    regRead(3'd3, r); check("R10 size", r, 32'(D));

    // R3 fill sweep with A=5 F=10, R2 storage
    regWrite(3'd2, 32'h000A0005);
    regWrite(3'd0, 32'h24);
    for (int c = 0; c <= D; c++) begin
      regRead(3'd1, r);
      check("R3 fill flags", r & 32'h0000F000, flagsOf(c, 5, 10));
      if (c < D) pushWord(32'hA5000000 + 32'(c));
    end
    // R4 overrun on full
    pushWord(32'hDEADBEEF);
    regRead(3'd1, r);
    check("R4 overrun set", r[23], 1'b1);
    check("R4 still full", r & 32'h0000F000, flagsOf(D, 5, 10));
    regWrite(3'd1, 32'h0);
    regRead(3'd1, r); check("R4 sticky on zero write", r[23], 1'b1);

    // R3 drain sweep with A=32 F=32, R2 order
    regWrite(3'd2, 32'h00200020);
    for (int c = D; c > 0; c--) begin
      regRead(3'd1, r);
      check("R3 drain flags", r & 32'h0000F000, flagsOf(c, 32, 32));
      regRead(3'd6, r);
      check("R2 data order", r, 32'hA5000000 + 32'(D - c));
    end
    regRead(3'd1, r);
    check("R3 empty flags", r & 32'h0000F000, flagsOf(0, 32, 32));

    // R5 underrun
    regRead(3'd6, r); check("R5 empty read zero", r, 32'h0);
    regRead(3'd1, r); check("R5 underrun set", r[22], 1'b1);
    regWrite(3'd1, 32'h0);
    regRead(3'd1, r); check("R5 sticky on zero write", r[22], 1'b1);
    regWrite(3'd1, 32'h00400000);
    regRead(3'd1, r); check("R5 underrun cleared", r[23:22], 2'b10);
    regWrite(3'd1, 32'h00800000);
    regRead(3'd1, r); check("R4 overrun cleared", r[23:22], 2'b00);

    // R6 disabled reception
    regWrite(3'd0, 32'h0);
    for (int k = 0; k < 3; k++) pushWord(32'h11110000 + 32'(k));
    regRead(3'd1, r); check("R6 nothing stored", r & 32'h00C0F000, flagsOf(0, 32, 32));

    // R7 FIFO reset keeps errors
    regWrite(3'd0, 32'h20);
    for (int k = 0; k < 5; k++) pushWord(32'h22220000 + 32'(k));
    regRead(3'd6, r); regRead(3'd6, r); regRead(3'd6, r);
    regRead(3'd6, r); regRead(3'd6, r); regRead(3'd6, r); // sixth read underruns
    for (int k = 0; k < 5; k++) pushWord(32'h33330000 + 32'(k));
    regWrite(3'd0, 32'h24);
    regRead(3'd1, r);
    check("R7 emptied", r & 32'h0000F000, flagsOf(0, 32, 32));
    check("R7 error kept", r[22], 1'b1);
    regRead(3'd0, r); check("R7 enable from same write", r, 32'h20);
    pushWord(32'h44440000);
    regRead(3'd6, r); check("R7 fresh data after reset", r, 32'h44440000);

    // R8 board reset with settle window
    regWrite(3'd4, 32'h0000F000);
    regWrite(3'd2, 32'h00050007);
    pushWord(32'h55550000);
    regWrite(3'd0, 32'h01);
    regRead(3'd1, r);
    check("R8 busy set", r[0], 1'b1);
    check("R8 errors cleared", r[23:22], 2'b00);
    regWrite(3'd0, 32'h20);
    pushWord(32'h66660000);
    regRead(3'd6, r); check("R8 busy read zero", r, 32'h0);
    regRead(3'd1, r);
    check("R8 busy no underrun", r[22], 1'b0);
    check("R8 busy nothing stored", r[12], 1'b0);
    regRead(3'd2, r); check("R8 thresholds default", r, 32'h00200020);
    regRead(3'd4, r); check("R8 enables cleared", r, 32'h0);
    regRead(3'd5, r); check("R8 pending cleared", r, 32'h0);
    repeat (SETTLE + 5) @(negedge clk);
    regRead(3'd1, r); check("R8 busy ends", r[0], 1'b0);
    pushWord(32'h77770000);
    regRead(3'd6, r); check("R8 access after settle", r, 32'h77770000);

    // R9 interrupt pending and gating
    regWrite(3'd5, 32'h0000F000);
    regRead(3'd5, r); check("R9 pending cleared", r, 32'h0);
    for (int k = 0; k < 32; k++) pushWord(32'h88880000 + 32'(k));
    regRead(3'd5, r); check("R9 almost-full pending", r, 32'h00004000);
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    regWrite(3'd4, 32'h00004000);
    check("R9 irq enabled", {31'b0, irq}, 32'h1);
    regWrite(3'd4, 32'h00001000);
    check("R9 irq other enable", {31'b0, irq}, 32'h0);
    for (int k = 32; k < D; k++) pushWord(32'h88880000 + 32'(k));
    regRead(3'd5, r); check("R9 full pending", r, 32'h0000C000);
    regWrite(3'd5, 32'h00004000);
    regRead(3'd5, r); check("R9 write-one clears", r, 32'h00008000);
    for (int k = 0; k < D; k++) begin
      regRead(3'd6, r);
      check("R2 drain after irq fill", r, 32'h88880000 + 32'(k));
    end
    regRead(3'd5, r); check("R9 empty and almost-empty pending", r, 32'h0000B000);
    check("R9 irq on empty", {31'b0, irq}, 32'h1);
    regWrite(3'd5, 32'h00001000);
    check("R9 irq dropped", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule